// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

The block keeps a 2048-byte bank of shared counters and applies one atomic command per clock from a processor I/O port. Every command names a byte address, an operand size and a direction. A load is a fetch-and-add. Its signed increment is packed into the upper part of the address word. The block returns the counter's value from before the update and writes the sum back in the same cycle. A store carries a data word. One address bit chooses whether that data is added to the counter or replaces it.

Each command finishes its read-modify-write in the clock edge that accepts it. A command issued in the next cycle therefore always sees the result of the one before, even when both touch the same bytes. The response comes one cycle after issue. It carries the old value sign-extended to 64 bits, or an error flag when the address is not naturally aligned for the operand size.

Top module: `atomic_counter_bank`

## Requirements
- R1: After a synchronous active-low reset every byte of the counter bank reads zero and `rsp_valid` is low.
- R2: Every command with `cmd_valid` high produces `rsp_valid` high exactly one cycle later, and no response appears without a command. On an accepted command `rsp_data` holds the operand's previous value, sign-extended from the operand width to 64 bits.
- R3: A load (`cmd_is_store` = 0) takes a 22-bit signed increment from `cmd_addr[35:14]`, sign-extends it to the operand size and writes back old value plus increment. `cmd_addr[13]` has no effect on a load.
- R4: On a store, `cmd_addr[13]` = 0 adds the low operand bits of `cmd_wdata` to the counter, and `cmd_addr[13]` = 1 overwrites the counter with them.
- R5: `cmd_size` encodes the operand as 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Sums wrap modulo the operand width.
- R6: The operand at byte address A of size n bytes occupies bytes A to A+n-1, and byte A is the least significant. Bytes outside the operand are never changed.
- R7: A command whose `cmd_addr[10:0]` is not a multiple of the operand size in bytes sets `rsp_err` and returns `rsp_data` = 0. It leaves the bank unmodified.
- R8: Commands issued in consecutive cycles to overlapping bytes are serialized, so each one observes the result of the command before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_is_store | input | 1 | 1 = store command, 0 = fetch-and-add load |
| cmd_addr | input | 36 | [10:0] byte address, [13] store mode, [35:14] load increment |
| cmd_size | input | 2 | Operand size code |
| cmd_wdata | input | 64 | Store data, low operand bits used |
| rsp_valid | output | 1 | Response for the command issued one cycle earlier |
| rsp_err | output | 1 | Address was misaligned; nothing was changed |
| rsp_data | output | 64 | Previous operand value, sign-extended |

## Verification
Two things can land in the same cycle: the read of a counter and the write-back of the command just before it to the same bytes. Runs of back-to-back commands on a small address window provoke this. The window mixes sizes so that narrow and wide operands overlap. Each response is compared with a byte-array reference model that applies the commands strictly in order. A stale read, or a lost update to a neighbouring lane, shows up as a wrong returned old value on a later command.

// File: rtl/fab_pkg.sv
// Package: shared operand-size encoding and data width for the counter bank.
// Assumes: 64-bit data path; size codes are fixed by the command format.
package fab_pkg;
    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } opsize_e;
endpackage

// File: rtl/fab_decode.sv
// Module: fab_decode
// Splits a command address into word index, lane shift, operand mask and
// byte enables, checks natural alignment and sign-extends the load increment.
// Assumes: the bank is organised as 64-bit words, little-endian byte lanes.
module fab_decode
    import fab_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int IDX_W   = 11,
    parameter int INC_LSB = 14,
    parameter int INC_W   = 22,
    localparam int WIDX_W = IDX_W - 3
) (
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_size,
    output logic [WIDX_W-1:0] word_idx,
    output logic [5:0]        bit_shift,
    output logic              aligned,
    output logic [7:0]        byte_en,
    output logic [DATA_W-1:0] width_mask,
    output logic [DATA_W-1:0] load_inc
);
    logic [2:0] offset;
    logic [7:0] base_be;
    logic [INC_W-1:0] inc_field;
    logic unused_addr_bits;

    assign unused_addr_bits = ^cmd_addr[INC_LSB-1:IDX_W];
    assign offset    = cmd_addr[2:0];
    assign word_idx  = cmd_addr[IDX_W-1:3];
    assign bit_shift = {offset, 3'b000};
    assign inc_field = cmd_addr[INC_LSB +: INC_W];

    // Sign-extend the increment field to the full data width.
    assign load_inc = {{(DATA_W-INC_W){inc_field[INC_W-1]}}, inc_field};

    // Size decode: alignment rule, operand mask and base byte enables.
    always_comb begin
        case (opsize_e'(cmd_size))
            SZ8: begin
                aligned    = 1'b1;
                width_mask = 64'h0000_0000_0000_00FF;
                base_be    = 8'h01;
            end
            SZ16: begin
                aligned    = (offset[0] == 1'b0);
                width_mask = 64'h0000_0000_0000_FFFF;
                base_be    = 8'h03;
            end
            SZ32: begin
                aligned    = (offset[1:0] == 2'b00);
                width_mask = 64'h0000_0000_FFFF_FFFF;
                base_be    = 8'h0F;
            end
            default: begin
                aligned    = (offset == 3'b000);
                width_mask = 64'hFFFF_FFFF_FFFF_FFFF;
                base_be    = 8'hFF;
            end
        endcase
    end

    // Byte lanes touched by the operand inside its 64-bit word.
    assign byte_en = 8'(base_be << offset);
endmodule

// File: rtl/fab_lane_alu.sv
// Module: fab_lane_alu
// Extracts the addressed operand from a bank word, sign-extends it for the
// response, forms the add or overwrite result and merges it back into the word.
// Assumes: the caller only writes merged data when the access is aligned.
module fab_lane_alu
    import fab_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [5:0]        bit_shift,
    input  logic [DATA_W-1:0] width_mask,
    input  logic [7:0]        byte_en,
    input  logic [1:0]        cmd_size,
    input  logic              is_store,
    input  logic              overwrite,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] load_inc,
    input  logic              check_en,
    output logic [DATA_W-1:0] old_ext,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] old_raw;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] lane_mask;

    assign old_raw   = (word >> bit_shift) & width_mask;
    assign operand   = is_store ? wdata : load_inc;
    assign lane_mask = width_mask << bit_shift;

    // Sign-extend the old operand from its width to 64 bits.
    always_comb begin
        case (opsize_e'(cmd_size))
            SZ8:     old_ext = {{56{old_raw[7]}},  old_raw[7:0]};
            SZ16:    old_ext = {{48{old_raw[15]}}, old_raw[15:0]};
            SZ32:    old_ext = {{32{old_raw[31]}}, old_raw[31:0]};
            default: old_ext = old_raw;
        endcase
    end

    // New operand value: overwrite on a store in replace mode, else wrap-add.
    assign result = (is_store && overwrite) ? operand : (old_raw + operand);

    // Put the new operand back into its lanes, keeping the others.
    assign merged = (word & ~lane_mask) | ((result & width_mask) << bit_shift);

    // Lanes outside the byte enables must reach the write port unchanged.
    always_comb begin
        if (check_en) begin
            for (int i = 0; i < 8; i++) begin
                if (!byte_en[i]) begin
                    // R6
                    lane_keep_chk: assert (merged[i*8 +: 8] == word[i*8 +: 8]);
                end
            end
        end
    end
endmodule

// File: rtl/fab_store.sv
// Module: fab_store
// The counter storage: one 64-bit register per word, combinational read and
// a single write port, all cleared by reset.
// Assumes: read and write use the same index in a cycle (read-modify-write).
module fab_store
    import fab_pkg::*;
#(
    parameter int WORDS   = 256,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDX_W-1:0] idx,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_word
);
    logic [DATA_W-1:0] words_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] q;

        // Hold one word; clear on reset, load when selected for write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (idx == WIDX_W'(g))) begin
                q <= wr_word;
            end
        end

        assign words_q[g] = q;
    end

    assign rd_word = words_q[idx];

    // R8
    wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (words_q[$past(idx)] == $past(wr_word)));
endmodule

// File: rtl/atomic_counter_bank.sv
// Module: atomic_counter_bank
// Atomic fetch-and-add / store-add / store-overwrite counter bank. Each
// command completes its read-modify-write at the accepting clock edge; the
// response follows one cycle later.
// Assumes: at most one command per cycle; misaligned commands are rejected.
module atomic_counter_bank
    import fab_pkg::*;
#(
    parameter int BYTES    = 2048,
    parameter int ADDR_W   = 36,
    parameter int INC_LSB  = 14,
    parameter int INC_W    = 22,
    parameter int MODE_BIT = 13,
    localparam int IDX_W   = $clog2(BYTES),
    localparam int WORDS   = BYTES / 8,
    localparam int WIDX_W  = IDX_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_store,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_size,
    input  logic [63:0]       cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_data
);
    logic [WIDX_W-1:0] word_idx;
    logic [5:0]        bit_shift;
    logic              aligned;
    logic [7:0]        byte_en;
    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] load_inc;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] old_ext;
    logic [DATA_W-1:0] merged;
    logic              wr_en;

    assign wr_en = cmd_valid && aligned;

    fab_decode #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .INC_LSB(INC_LSB),
        .INC_W  (INC_W)
    ) u_decode (
        .cmd_addr  (cmd_addr),
        .cmd_size  (cmd_size),
        .word_idx  (word_idx),
        .bit_shift (bit_shift),
        .aligned   (aligned),
        .byte_en   (byte_en),
        .width_mask(width_mask),
        .load_inc  (load_inc)
    );

    fab_store #(
        .WORDS(WORDS)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (word_idx),
        .rd_word(rd_word),
        .wr_en  (wr_en),
        .wr_word(merged)
    );

    fab_lane_alu u_alu (
        .word      (rd_word),
        .bit_shift (bit_shift),
        .width_mask(width_mask),
        .byte_en   (byte_en),
        .cmd_size  (cmd_size),
        .is_store  (cmd_is_store),
        .overwrite (cmd_addr[MODE_BIT]),
        .wdata     (cmd_wdata),
        .load_inc  (load_inc),
        .check_en  (wr_en && rst_n),
        .old_ext   (old_ext),
        .merged    (merged)
    );

    // Register the response for the command accepted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_err   <= cmd_valid && !aligned;
            rsp_data  <= wr_en ? old_ext : '0;
        end
    end

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    // R7
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !aligned) |=> (rsp_err && (rsp_data == '0)));

    // R2
    byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && ($past(cmd_size) == 2'd0)) |->
        ((rsp_data[63:7] == '0) || (rsp_data[63:7] == '1)));
endmodule

// File: tb/atomic_counter_bank_test.sv
`timescale 1ns/1ps
module atomic_counter_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_is_store = 1'b0;
    logic [35:0] cmd_addr = '0;
    logic [1:0]  cmd_size = '0;
    logic [63:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_data;

    int checks = 0;
    int failures = 0;
    logic [7:0] ref_mem [2048];

    always #4 clk = ~clk;

    atomic_counter_bank uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_is_store(cmd_is_store), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_data(rsp_data)
    );

    function automatic logic [35:0] mk(input int idx, input logic [21:0] inc, input logic mode);
        return {inc, mode, 2'b00, 11'(idx)};
    endfunction

    task automatic check(input string req, input logic [65:0] got, input logic [65:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // Reference: apply one command to ref_mem in order, give expected response.
    task automatic model(input logic st, input logic [35:0] a, input logic [1:0] sz,
                         input logic [63:0] wd, output logic e_err, output logic [63:0] e_data);
        int n, base, sh;
        logic [63:0] old, opnd, nv;
        n = 1 << sz;
        base = int'(a[10:0]);
        if ((base % n) != 0) begin
            e_err = 1'b1;
            e_data = '0;
            return;
        end
        old = '0;
        for (int i = 0; i < n; i++) old |= 64'(ref_mem[base+i]) << (8*i);
        sh = 64 - 8*n;
        e_data = 64'($signed(old << sh) >>> sh);
        e_err = 1'b0;
        opnd = st ? wd : {{42{a[35]}}, a[35:14]};
        nv = (st && a[13]) ? opnd : old + opnd;
        for (int i = 0; i < n; i++) ref_mem[base+i] = nv[8*i +: 8];
    endtask

    // Issue one command (kept valid across calls for back-to-back) and check it.
    task automatic op(input string req, input logic st, input logic [35:0] a,
                      input logic [1:0] sz, input logic [63:0] wd);
        logic e_err;
        logic [63:0] e_data;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_is_store = st;
        cmd_addr = a;
        cmd_size = sz;
        cmd_wdata = wd;
        model(st, a, sz, wd, e_err, e_data);
        @(posedge clk);
        #2;
        check(req, {rsp_valid, rsp_err, rsp_data}, {1'b1, e_err, e_data});
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        for (int i = 0; i < 2048; i++) ref_mem[i] = 8'h00;
        seed = $urandom(32'd1234);
        repeat (4) @(posedge clk);
        #2;
        check("R1 rsp_valid in reset", {65'd0, rsp_valid}, 66'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1 rsp_valid after reset", {65'd0, rsp_valid}, 66'd0);

        // R1: counters read zero after reset, including the top of the bank
        op("R1 zero top", 1'b0, mk(2040, 22'd0, 1'b0), 2'd3, '0);
        op("R1 zero low", 1'b0, mk(0, 22'd0, 1'b0), 2'd3, '0);
        // R3: positive and negative increments, bit 13 ignored on loads
        op("R3 inc +5", 1'b0, mk(16, 22'd5, 1'b1), 2'd2, '0);
        op("R3 inc -3", 1'b0, mk(16, 22'h3FFFFD, 1'b0), 2'd2, '0);
        op("R3 read back", 1'b0, mk(16, 22'd0, 1'b0), 2'd2, '0);
        op("R3 most negative", 1'b0, mk(88, 22'h200000, 1'b0), 2'd3, '0);
        op("R3 most negative read", 1'b0, mk(88, 22'd0, 1'b0), 2'd3, '0);
        idle();
        // R5: 8-bit wrap from 0x7F to -128
        op("R5 set 0x7F", 1'b1, mk(33, 22'd0, 1'b1), 2'd0, 64'h7F);
        op("R5 wrap add", 1'b0, mk(33, 22'd1, 1'b0), 2'd0, '0);
        op("R5 wrapped value", 1'b0, mk(33, 22'd0, 1'b0), 2'd0, '0);
        // R4: store add and store overwrite
        op("R4 store add", 1'b1, mk(48, 22'd0, 1'b0), 2'd1, 64'h1234);
        op("R4 store add twice", 1'b1, mk(48, 22'd0, 1'b0), 2'd1, 64'hFFFF_1234);
        op("R4 sum", 1'b0, mk(48, 22'd0, 1'b0), 2'd1, '0);
        // R6: byte write inside a 64-bit counter keeps its neighbours
        op("R6 fill", 1'b1, mk(64, 22'd0, 1'b1), 2'd3, 64'h1122_3344_5566_7788);
        op("R6 byte", 1'b1, mk(67, 22'd0, 1'b1), 2'd0, 64'hAB);
        op("R6 word", 1'b0, mk(64, 22'd0, 1'b0), 2'd3, '0);
        // R7: misaligned commands flag error and leave data untouched
        op("R7 store misaligned", 1'b1, mk(66, 22'd0, 1'b1), 2'd2, 64'hDEAD_BEEF);
        op("R7 load misaligned", 1'b0, mk(68, 22'd9, 1'b0), 2'd3, '0);
        op("R7 half misaligned", 1'b0, mk(65, 22'd9, 1'b0), 2'd1, '0);
        op("R7 unchanged", 1'b0, mk(64, 22'd0, 1'b0), 2'd3, '0);
        idle();
        // R8: back-to-back increments on one counter return 0,1,2,...
        for (int k = 0; k < 5; k++) op("R8 chain", 1'b0, mk(80, 22'd1, 1'b0), 2'd3, '0);
        op("R8 narrow after wide", 1'b0, mk(82, 22'd7, 1'b0), 2'd1, '0);
        op("R8 wide after narrow", 1'b0, mk(80, 22'd0, 1'b0), 2'd3, '0);
        idle();

        // Random mix over a small window, back-to-back, against the reference.
        for (int k = 0; k < 600; k++) begin
            logic st;
            logic [1:0] sz;
            int a;
            logic [63:0] wd;
            st = 1'($urandom);
            sz = 2'($urandom);
            a = int'($urandom % 64);
            if (($urandom % 10) != 0) a = a & ~((1 << sz) - 1);
            wd = {$urandom, $urandom};
            if ((a % (1 << sz)) != 0)
                op("R7 random", st, mk(a, 22'($urandom), 1'($urandom)), sz, wd);
            else if (st)
                op("R4 random", st, mk(a, 22'($urandom), 1'($urandom)), sz, wd);
            else
                op("R8 random", st, mk(a, 22'($urandom), 1'($urandom)), sz, wd);
            if (($urandom % 8) == 0) idle();
        end
        idle();
        @(posedge clk);
        #2;
        check("R2 no response when idle", {65'd0, rsp_valid}, 66'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule